// File: doc/BRIEF.md
# Multicast Cell Replicating Ingress Interface

This block sits between the head of one input line card queue and the first fabric router of its row. Cells arrive one at a time over a valid/ready handshake. Each carries a payload and a destination mask with one bit per switch output port, where a 1 in bit k names output k as a destination. Only the cell at the head of the line card queue is offered, and it moves into the block only when the block's single cell holding register is free.

A mode input picks between two ways of injecting the cell into the fabric. In copy mode the block walks the destination mask from the lowest index upward and emits one unicast packet per destination, each carrying a mask with exactly that one bit set. In multicast mode it emits the cell once with its complete mask and leaves replication to the routers. Payload bits pass through untouched in both modes. A cell whose mask is all zeros has no destination; it is dropped on arrival and a saturating fault counter records it.

Top module: `mcast_ingress_rep`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and `err_count` is 0; `in_ready` is 1 exactly when no cell is held.
- R2: In copy mode (`in_mode` = 0 at acceptance) a cell with k set mask bits yields exactly k output packets, each with a single set bit in `out_mask`.
- R3: Copies leave in ascending destination index order, at most one per cycle; the first copy is valid in the cycle after the cell is accepted.
- R4: In multicast mode (`in_mode` = 1 at acceptance) a cell yields exactly one output packet whose `out_mask` equals the full input mask.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_mask` and `out_payload` hold their values into the next cycle.
- R6: While any packet of a cell is still pending, `in_ready` is 0 and no new cell is taken; `in_ready` returns to 1 in the cycle after the last packet is accepted.
- R7: An accepted cell with an all-zero mask produces no packet, leaves `in_ready` at 1, and raises `err_count` by one, saturating at its all-ones value.
- R8: Every output packet carries the payload of its cell unchanged.
- R9: The mode is sampled when the cell is accepted; changing `in_mode` while packets are pending does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_mode | input | 1 | 0 copy mode, 1 multicast mode, sampled on acceptance |
| in_valid | input | 1 | Head cell offered by the line card queue |
| in_ready | output | 1 | Holding register free, cell can be taken |
| in_mask | input | NUM_PORTS | Destination mask, bit k selects output k |
| in_payload | input | PAYLOAD_W | Cell payload |
| out_valid | output | 1 | Packet offered to the router |
| out_ready | input | 1 | Router input buffer has space |
| out_mask | output | NUM_PORTS | Destination mask of the offered packet |
| out_payload | output | PAYLOAD_W | Payload of the offered packet |
| err_count | output | ERR_W | Saturating count of dropped empty-mask cells |

## Verification
A wrong remaining-mask register shows at the ports within one accepted packet: the next copy carries a wrong or repeated bit, the copy count differs from the mask's population, or the block stalls with `in_ready` low. A wrong held-valid bit shows in the same cycle as `in_ready` and `out_valid` disagreeing with the number of packets already taken, and a wrong latched mode shows on the first packet of the cell as a full mask where a single bit was due, or the reverse. Every mask value of a four-port configuration is swept in both modes, with the router both always ready and stalling every other cycle, so each of these faults reaches a port compare within a few cycles.

// File: rtl/rep_pkg.sv
package rep_pkg;
  typedef enum logic {
    FAN_COPY  = 1'b0,
    FAN_MCAST = 1'b1
  } fan_mode_e;
endpackage

// File: rtl/rep_lowbit_pick.sv
module rep_lowbit_pick #(
  parameter int W = 8
) (
  input  logic [W-1:0] mask,
  output logic [W-1:0] onehot,
  output logic [W-1:0] rest,
  output logic         any
);
  logic [W:0] seen;

  assign seen[0] = 1'b0;

  // Prefix chain: a bit is selected when it is set and no lower bit is set.
  for (genvar g = 0; g < W; g++) begin : g_pick
    assign onehot[g]  = mask[g] & ~seen[g];
    assign seen[g+1]  = seen[g] | mask[g];
  end

  assign rest = mask & ~onehot;
  assign any  = seen[W];
endmodule

// File: rtl/rep_fault_count.sv
module rep_fault_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bump,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] count_q;
  logic [CW-1:0] count_d;
  logic          count_en;

  always_comb begin
    count_en = bump && (count_q != CNT_MAX);
    count_d  = count_q + {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/rep_fanout_state.sv
module rep_fanout_state #(
  parameter int W  = 8,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_mask,
  input  logic [PW-1:0] load_payload,
  input  logic          load_mode,
  input  logic          advance,
  input  logic [W-1:0]  rest_mask,
  output logic          hold_valid,
  output logic [W-1:0]  hold_mask,
  output logic [PW-1:0] hold_payload,
  output logic          hold_mode
);
  import rep_pkg::*;

  logic          valid_q, valid_d;
  logic [W-1:0]  mask_q,  mask_d;
  logic [PW-1:0] pay_q;
  logic          mode_q;
  logic          upd_en;
  logic          last_pkt;

  always_comb begin
    last_pkt = (mode_q == FAN_MCAST) || (rest_mask == '0);
    upd_en   = load || advance;
    valid_d  = valid_q;
    mask_d   = mask_q;
    if (load) begin
      valid_d = 1'b1;
      mask_d  = load_mask;
    end else if (advance) begin
      valid_d = !last_pkt;
      mask_d  = last_pkt ? mask_q : rest_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      mask_q  <= mask_d;
    end
  end

  // Payload and mode change only on load; they stay put while copies drain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_q  <= '0;
      mode_q <= FAN_COPY;
    end else if (load) begin
      pay_q  <= load_payload;
      mode_q <= load_mode;
    end
  end

  assign hold_valid   = valid_q;
  assign hold_mask    = mask_q;
  assign hold_payload = pay_q;
  assign hold_mode    = mode_q;
endmodule

// File: rtl/mcast_ingress_rep.sv
module mcast_ingress_rep #(
  parameter int NUM_PORTS = 8,
  parameter int PAYLOAD_W = 16,
  parameter int ERR_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_mode,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NUM_PORTS-1:0] in_mask,
  input  logic [PAYLOAD_W-1:0] in_payload,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NUM_PORTS-1:0] out_mask,
  output logic [PAYLOAD_W-1:0] out_payload,
  output logic [ERR_W-1:0]     err_count
);
  import rep_pkg::*;

  logic                 accept;
  logic                 mask_empty;
  logic                 cell_load;
  logic                 cell_drop;
  logic                 pkt_fire;
  logic                 hold_valid;
  logic [NUM_PORTS-1:0] hold_mask;
  logic [PAYLOAD_W-1:0] hold_payload;
  logic                 hold_mode;
  logic [NUM_PORTS-1:0] pick_onehot;
  logic [NUM_PORTS-1:0] pick_rest;
  logic                 pick_any;

  always_comb begin
    in_ready   = !hold_valid;
    accept     = in_valid && in_ready;
    mask_empty = (in_mask == '0);
    cell_load  = accept && !mask_empty;
    cell_drop  = accept && mask_empty;
    pkt_fire   = hold_valid && out_ready;
  end

  rep_lowbit_pick #(.W(NUM_PORTS)) u_pick (
    .mask   (hold_mask),
    .onehot (pick_onehot),
    .rest   (pick_rest),
    .any    (pick_any)
  );

  rep_fanout_state #(.W(NUM_PORTS), .PW(PAYLOAD_W)) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (cell_load),
    .load_mask    (in_mask),
    .load_payload (in_payload),
    .load_mode    (in_mode),
    .advance      (pkt_fire),
    .rest_mask    (pick_rest),
    .hold_valid   (hold_valid),
    .hold_mask    (hold_mask),
    .hold_payload (hold_payload),
    .hold_mode    (hold_mode)
  );

  rep_fault_count #(.CW(ERR_W)) u_fault (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (cell_drop),
    .count (err_count)
  );

  always_comb begin
    out_valid   = hold_valid && pick_any;
    out_mask    = (hold_mode == FAN_MCAST) ? hold_mask : pick_onehot;
    out_payload = hold_payload;
  end
endmodule

// File: rtl/rep_checker.sv
module rep_checker #(
  parameter int W  = 8,
  parameter int PW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [W-1:0]  in_mask,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_mask,
  input logic [PW-1:0] out_payload,
  input logic [CW-1:0] err_count,
  input logic          hold_mode
);
  localparam logic [CW-1:0] CNT_TOP = '1;

  // R1: offering a packet and taking a cell never overlap
  a_r1_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R2: a copy-mode packet names one destination only
  a_r2_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !hold_mode) |-> ($countones(out_mask) == 1));

  // R3: the next copy of the same cell names a higher output
  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !hold_mode) |=> (!out_valid || (out_mask > $past(out_mask))));

  // R4: no packet leaves with an empty mask
  a_r4_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask != '0));

  // R5: a stalled packet keeps its content
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mask) && $stable(out_payload)));

  // R6: after the last multicast packet leaves, the block is free
  a_r6_mcast_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && hold_mode) |=> (in_ready && !out_valid));

  // R7: the counter moves only for an accepted empty-mask cell
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && (in_mask == '0)) |=> $stable(err_count));

  // R7: an accepted empty-mask cell steps the counter unless it is full
  a_r7_err_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_mask == '0) && (err_count != CNT_TOP))
      |=> (err_count == CW'($past(err_count) + 1'b1)));
endmodule

bind mcast_ingress_rep rep_checker #(.W(NUM_PORTS), .PW(PAYLOAD_W), .CW(ERR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_mask     (in_mask),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_mask    (out_mask),
  .out_payload (out_payload),
  .err_count   (err_count),
  .hold_mode   (hold_mode)
);

// File: tb/sim_mcast_ingress_rep.sv
module sim_mcast_ingress_rep;
  localparam int NP = 4;
  localparam int PW = 12;
  localparam int EW = 3;
  localparam int ERR_TOP = (1 << EW) - 1;

  logic          clk;
  logic          rst_n;
  logic          in_mode;
  logic          in_valid;
  logic          in_ready;
  logic [NP-1:0] in_mask;
  logic [PW-1:0] in_payload;
  logic          out_valid;
  logic          out_ready;
  logic [NP-1:0] out_mask;
  logic [PW-1:0] out_payload;
  logic [EW-1:0] err_count;

  int vectors;
  int misses;
  int err_exp;

  mcast_ingress_rep #(.NUM_PORTS(NP), .PAYLOAD_W(PW), .ERR_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_mode(in_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_mask(in_mask), .in_payload(in_payload),
    .out_valid(out_valid), .out_ready(out_ready), .out_mask(out_mask),
    .out_payload(out_payload), .err_count(err_count)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_cell(input logic [NP-1:0] m, input bit md,
                           input logic [PW-1:0] pl, input bit stall);
    logic [NP-1:0] exp_q [NP];
    int nexp;
    int idx;
    int k;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready when idle", int'(in_ready), 1);
    in_valid   = 1'b1;
    in_mask    = m;
    in_mode    = md;
    in_payload = pl;
    out_ready  = 1'b0;
    @(negedge clk);
    in_mode  = ~md;   // R9: flipped while the cell is pending
    in_valid = 1'b0;
    if (m == '0) begin
      if (err_exp < ERR_TOP) err_exp++;
      chk(out_valid == 1'b0, "R7 empty mask emits nothing", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R7 ready stays high", int'(in_ready), 1);
      chk(int'(err_count) == err_exp, "R7 fault count", int'(err_count), err_exp);
      return;
    end
    nexp = 0;
    if (md) begin
      exp_q[0] = m;
      nexp = 1;
    end else begin
      for (int b = 0; b < NP; b++) begin
        if (m[b]) begin
          exp_q[nexp] = NP'(1) << b;
          nexp++;
        end
      end
    end
    idx = 0;
    k = 0;
    while (idx < nexp && k < 4 * NP + 4) begin
      bit rdy;
      chk(out_valid == 1'b1, "R3 packet valid", int'(out_valid), 1);
      chk(out_mask == exp_q[idx], md ? "R4 R9 multicast mask" : (k > 0 && stall ? "R5 R2 stalled copy mask" : "R2 R3 R9 copy mask"),
          int'(out_mask), int'(exp_q[idx]));
      chk(out_payload == pl, "R8 payload", int'(out_payload), int'(pl));
      chk(in_ready == 1'b0, "R6 busy while pending", int'(in_ready), 0);
      rdy = stall ? (k % 2 == 1) : 1'b1;
      out_ready  = rdy;
      in_valid   = !(rdy && idx == nexp - 1);
      in_mask    = ~m;
      in_payload = ~pl;
      @(negedge clk);
      if (rdy) idx++;
      k++;
    end
    out_ready = 1'b0;
    in_valid  = 1'b0;
    chk(out_valid == 1'b0, "R2 R4 R6 no extra packet", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R6 ready after last packet", int'(in_ready), 1);
    chk(int'(err_count) == err_exp, "R7 count unchanged", int'(err_count), err_exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL R6 watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    vectors    = 0;
    misses     = 0;
    err_exp    = 0;
    rst_n      = 1'b0;
    in_mode    = 1'b0;
    in_valid   = 1'b0;
    in_mask    = '0;
    in_payload = '0;
    out_ready  = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    chk(err_count == '0, "R1 reset count", int'(err_count), 0);
    rst_n = 1'b1;
    for (int md = 0; md < 2; md++) begin
      for (int st = 0; st < 2; st++) begin
        for (int m = 0; m < (1 << NP); m++) begin
          send_cell(NP'(m), md[0], PW'(m * 37 + md * 5 + st * 401), st[0]);
        end
      end
    end
    for (int z = 0; z < 6; z++) begin
      send_cell('0, z[0], PW'(z), 1'b0);
    end
    chk(int'(err_count) == ERR_TOP, "R7 saturation", int'(err_count), ERR_TOP);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule